// File: doc/BRIEF.md
# Prioritized Trace Message Queue

This block collects trace messages from four producers (watchpoint, ownership, branch and data trace) and holds them in a first-in first-out queue until a downstream port takes them over a valid/ready stream. Any subset of the producers may present a message in the same cycle. At most one message enters the queue per cycle, chosen by a fixed priority. A branch message that loses to a watchpoint or ownership message is reported by an error message in the following cycle.

When a message cannot be stored because the queue is full, the block does not just drop that one message. It stops accepting anything and lets the consumer drain the queue completely. While it drains, it notes which message kinds tried to get in. Once the queue is empty it writes one error message that carries this mask. Side outputs report a lost branch message and the overrun state to the branch trace producer. The queue itself tags the next stored branch message as a resynchronizing one.

Top module: `trace_msg_queue`

## Requirements
- R1: Message kinds are coded watchpoint=0, ownership=1, branch=2, data=3, error=4 on `out_kind`. When several producers are valid in one cycle, exactly one message is stored, chosen in the order watchpoint, ownership, branch, data. Its payload is the winning producer's data.
- R2: A branch message that is valid in the same cycle as a watchpoint or ownership message is not stored, and `br_lost` is high in that cycle. In the next cycle an error message (kind 4) with payload 0x04 is stored: bit 2 marks the branch kind and bit 4 is zero.
- R3: A pending collision error takes the write slot ahead of new branch and data messages. A branch message lost this way raises `br_lost` but causes no further error message.
- R4: A data message that loses arbitration is discarded without any error message.
- R5: If the chosen message arrives while the queue holds DEPTH entries, the queue enters overrun and `ovr_active` goes high after that edge. Every message that arrives until the queue is empty is discarded, and the stored messages still leave in order.
- R6: In the cycle after the queue has emptied during overrun, an error message is stored and `ovr_active` falls. Its payload has bit 4 set and bits 3:0 hold the mask (bit n = kind n) of every kind that was valid from the overflowing cycle through the error write. The mask then clears.
- R7: The first branch message stored after reset, after a collision loss or after an overrun has `out_sync`=1. Later branch messages have `out_sync`=0. `sync_req` is high while such a sync is owed.
- R8: Stored messages leave in arrival order with kind, sync flag and payload intact. `out_valid` is high while the queue is not empty, and an entry leaves on a cycle with `out_valid` and `out_ready` both high.
- R9: After reset the queue is empty, `ovr_active` is low and `sync_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_valid | input | 1 | Watchpoint message present |
| wp_data | input | PW | Watchpoint payload |
| own_valid | input | 1 | Ownership message present |
| own_data | input | PW | Ownership payload |
| br_valid | input | 1 | Branch message present |
| br_data | input | PW | Branch payload |
| dt_valid | input | 1 | Data trace message present |
| dt_data | input | PW | Data trace payload |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Consumer takes the head |
| out_kind | output | 3 | Kind code of the head |
| out_sync | output | 1 | Head is a resynchronizing branch message |
| out_data | output | PW | Payload of the head |
| br_lost | output | 1 | A branch message offered this cycle is not stored |
| ovr_active | output | 1 | Queue is draining after an overrun |
| sync_req | output | 1 | Next stored branch message will carry sync |

## Verification
The bench goes after same-cycle contention among all four producers. A wrong priority order or a missed collision would show up as the wrong head kind, or as a missing or extra error message one cycle later. It also checks the case where a pending collision error meets new branch and data messages; a design that let the branch win, or that raised a second error, would shift the whole output sequence. The overrun test fills the queue, offers new kinds while it drains and then reads everything out. A design that stored any of those late arrivals, wrote the error before the queue was empty, or built its mask from the wrong cycles would produce an extra entry or a wrong error payload. Sync tagging is checked after reset, after a collision and after an overrun, where a design that forgot to rearm would emit a plain branch message.

// File: rtl/tmq_pkg.sv
package tmq_pkg;
    localparam int NSRC = 4;
    localparam logic [2:0] K_WP   = 3'd0;
    localparam logic [2:0] K_OWN  = 3'd1;
    localparam logic [2:0] K_BR   = 3'd2;
    localparam logic [2:0] K_DT   = 3'd3;
    localparam logic [2:0] K_ERR  = 3'd4;
    // arbitration slot indices, highest priority at bit 0
    localparam int S_WP  = 0;
    localparam int S_OWN = 1;
    localparam int S_ERR = 2;
    localparam int S_BR  = 3;
    localparam int S_DT  = 4;
    localparam int NSLOT = 5;
endpackage

// File: rtl/tmq_prio_arb.sv
module tmq_prio_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // lowest index wins: isolate the least significant set bit
    always_comb begin
        grant = req & (~req + N'(1));
    end
endmodule

// File: rtl/tmq_fifo.sv
module tmq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 20,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t fifo_d, fifo_q;

    always_comb begin
        fifo_d = fifo_q;
        if (wr_en) begin
            fifo_d.mem[fifo_q.wptr] = wr_data;
            fifo_d.wptr = (fifo_q.wptr == AW'(DEPTH - 1)) ? '0 : fifo_q.wptr + 1'b1;
        end
        if (rd_en) begin
            fifo_d.rptr = (fifo_q.rptr == AW'(DEPTH - 1)) ? '0 : fifo_q.rptr + 1'b1;
        end
        case ({wr_en, rd_en})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign rd_data = fifo_q.mem[fifo_q.rptr];
    assign count   = fifo_q.cnt;
endmodule

// File: rtl/trace_msg_queue.sv
module trace_msg_queue
    import tmq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 16,
    localparam int EW   = PW + 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_valid,
    input  logic [PW-1:0] wp_data,
    input  logic          own_valid,
    input  logic [PW-1:0] own_data,
    input  logic          br_valid,
    input  logic [PW-1:0] br_data,
    input  logic          dt_valid,
    input  logic [PW-1:0] dt_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [2:0]    out_kind,
    output logic          out_sync,
    output logic [PW-1:0] out_data,
    output logic          br_lost,
    output logic          ovr_active,
    output logic          sync_req
);
    typedef struct packed {
        logic            ovr;
        logic [NSRC-1:0] mask;
        logic            coll;
        logic            need_sync;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [NSRC-1:0]  vld;
    logic [NSLOT-1:0] req, grant;
    logic             wr_en, rd_en, full, empty;
    logic [EW-1:0]    wr_entry, rd_entry;
    logic [CW-1:0]    count;
    logic [PW-1:0]    err_pay;

    assign vld = {dt_valid, br_valid, own_valid, wp_valid};

    always_comb begin
        req        = '0;
        req[S_WP]  = wp_valid;
        req[S_OWN] = own_valid;
        req[S_ERR] = ctl_q.coll;
        req[S_BR]  = br_valid;
        req[S_DT]  = dt_valid;
    end

    tmq_prio_arb #(.N(NSLOT)) u_arb (
        .req   (req),
        .grant (grant)
    );

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rd_en = out_valid && out_ready;

    always_comb begin
        ctl_d    = ctl_q;
        wr_en    = 1'b0;
        wr_entry = '0;
        br_lost  = 1'b0;
        err_pay  = '0;
        if (ctl_q.ovr) begin
            // draining: nothing new enters, remember who tried
            br_lost = br_valid;
            if (empty) begin
                err_pay[4]   = 1'b1;
                err_pay[3:0] = ctl_q.mask | vld;
                wr_en        = 1'b1;
                wr_entry     = {K_ERR, 1'b0, err_pay};
                ctl_d.ovr    = 1'b0;
                ctl_d.mask   = '0;
            end else begin
                ctl_d.mask = ctl_q.mask | vld;
            end
        end else if (|grant) begin
            if (full) begin
                br_lost         = br_valid;
                ctl_d.ovr       = 1'b1;
                ctl_d.mask      = vld | (ctl_q.coll ? 4'b0100 : 4'b0000);
                ctl_d.coll      = 1'b0;
                ctl_d.need_sync = 1'b1;
            end else begin
                wr_en   = 1'b1;
                br_lost = br_valid && !grant[S_BR];
                if (grant[S_WP]) begin
                    wr_entry = {K_WP, 1'b0, wp_data};
                end else if (grant[S_OWN]) begin
                    wr_entry = {K_OWN, 1'b0, own_data};
                end else if (grant[S_ERR]) begin
                    err_pay[2] = 1'b1;
                    wr_entry   = {K_ERR, 1'b0, err_pay};
                    ctl_d.coll = 1'b0;
                end else if (grant[S_BR]) begin
                    wr_entry        = {K_BR, ctl_q.need_sync, br_data};
                    ctl_d.need_sync = 1'b0;
                end else begin
                    wr_entry = {K_DT, 1'b0, dt_data};
                end
                if (br_lost) begin
                    ctl_d.need_sync = 1'b1;
                    if (wp_valid || own_valid) ctl_d.coll = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.need_sync <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    tmq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_entry),
        .rd_en   (rd_en),
        .rd_data (rd_entry),
        .count   (count)
    );

    assign out_valid  = !empty;
    assign out_kind   = rd_entry[EW-1 -: 3];
    assign out_sync   = rd_entry[PW];
    assign out_data   = rd_entry[PW-1:0];
    assign ovr_active = ctl_q.ovr;
    assign sync_req   = ctl_q.need_sync;
endmodule

// File: rtl/tmq_checker.sv
module tmq_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ovr_q,
    input logic          coll_q,
    input logic [CW-1:0] count,
    input logic          wr_en,
    input logic          wp_valid,
    input logic          own_valid,
    input logic          br_valid,
    input logic          br_lost,
    input logic          sync_req
);
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5
    drain_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && count != '0) |-> !wr_en);

    // R6
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && count == '0) |-> wr_en ##1 !ovr_q);

    // R2
    collision_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && (wp_valid || own_valid) && !ovr_q && count != CW'(DEPTH)) |=> coll_q);

    // R7
    lost_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_lost |=> sync_req);
endmodule

bind trace_msg_queue tmq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovr_q     (ctl_q.ovr),
    .coll_q    (ctl_q.coll),
    .count     (count),
    .wr_en     (wr_en),
    .wp_valid  (wp_valid),
    .own_valid (own_valid),
    .br_valid  (br_valid),
    .br_lost   (br_lost),
    .sync_req  (sync_req)
);

// File: tb/tb_trace_msg_queue.sv
`timescale 1ns/1ps
module tb_trace_msg_queue;
    localparam int DEPTH = 8;
    localparam int PW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_valid = 0, own_valid = 0, br_valid = 0, dt_valid = 0;
    logic [PW-1:0] wp_data = '0, own_data = '0, br_data = '0, dt_data = '0;
    logic          out_valid, out_ready = 1'b0, out_sync, br_lost, ovr_active, sync_req;
    logic [2:0]    out_kind;
    logic [PW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    trace_msg_queue #(.DEPTH(DEPTH), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .wp_valid(wp_valid), .wp_data(wp_data),
        .own_valid(own_valid), .own_data(own_data),
        .br_valid(br_valid), .br_data(br_data),
        .dt_valid(dt_valid), .dt_data(dt_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_sync(out_sync), .out_data(out_data),
        .br_lost(br_lost), .ovr_active(ovr_active), .sync_req(sync_req)
    );

    typedef struct packed {
        logic [3:0] vld;    // {dt, br, own, wp}
        logic       ev;     // head expected valid
        logic [2:0] ek;     // expected kind
        logic       es;     // expected sync
        logic [7:0] ep;     // expected payload for error kind
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'b0100, 1'b1, 3'd2, 1'b1, 8'h00},  // R7 first branch after reset
        '{4'b0100, 1'b1, 3'd2, 1'b0, 8'h00},  // R7 plain branch
        '{4'b1000, 1'b1, 3'd3, 1'b0, 8'h00},  // R8 data
        '{4'b0001, 1'b1, 3'd0, 1'b0, 8'h00},  // R8 watchpoint
        '{4'b0010, 1'b1, 3'd1, 1'b0, 8'h00},  // R8 ownership
        '{4'b1111, 1'b1, 3'd0, 1'b0, 8'h00},  // R1 all four
        '{4'b0000, 1'b1, 3'd4, 1'b0, 8'h04},  // R2 collision error
        '{4'b0100, 1'b1, 3'd2, 1'b1, 8'h00},  // R7 sync after collision
        '{4'b1010, 1'b1, 3'd1, 1'b0, 8'h00},  // R1 own over data
        '{4'b0000, 1'b0, 3'd0, 1'b0, 8'h00},  // R4 no error for lost data
        '{4'b0110, 1'b1, 3'd1, 1'b0, 8'h00},  // R2 own beats branch
        '{4'b1100, 1'b1, 3'd4, 1'b0, 8'h04},  // R3 error beats branch/data
        '{4'b0100, 1'b1, 3'd2, 1'b1, 8'h00},  // R3 no second error, sync
        '{4'b1001, 1'b1, 3'd0, 1'b0, 8'h00}   // R1 wp over data
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO check FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input int tag);
        wp_valid  = v[0]; own_valid = v[1]; br_valid = v[2]; dt_valid = v[3];
        wp_data   = PW'(tag * 16 + 0);
        own_data  = PW'(tag * 16 + 1);
        br_data   = PW'(tag * 16 + 2);
        dt_data   = PW'(tag * 16 + 3);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0]    got_k [20];
        logic [PW-1:0] got_p [20];
        int            ngot;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", 32'(out_valid), 32'd0);
        chk("R9 ovr_active", 32'(ovr_active), 32'd0);
        chk("R9 sync_req", 32'(sync_req), 32'd1);

        // table walk: consumer always ready, each stored entry is the head for one cycle
        out_ready = 1'b1;
        drive(VEC[0].vld, 0);
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R8 row%0d valid", i), 32'(out_valid), 32'(VEC[i].ev));
            if (VEC[i].ev) begin
                chk($sformatf("R1 row%0d kind", i), 32'(out_kind), 32'(VEC[i].ek));
                chk($sformatf("R7 row%0d sync", i), 32'(out_sync), 32'(VEC[i].es));
                if (VEC[i].ek == 3'd4)
                    chk($sformatf("R2 row%0d err payload", i), 32'(out_data), 32'(VEC[i].ep));
                else
                    chk($sformatf("R8 row%0d payload", i), 32'(out_data), 32'(i * 16 + int'(VEC[i].ek)));
            end
            if (i + 1 < NV) drive(VEC[i + 1].vld, i + 1);
            else            drive(4'b0000, 0);
        end

        // R2 br_lost pulse seen in the collision cycle
        drive(4'b0101, 30);
        #0.1;
        chk("R2 br_lost on collision", 32'(br_lost), 32'd1);
        @(posedge clk); @(negedge clk);
        drive(4'b0000, 0);
        repeat (3) @(negedge clk);   // error written then popped, sync owed
        chk("R7 sync_req after collision", 32'(sync_req), 32'd1);
        drive(4'b0100, 31);
        @(posedge clk); @(negedge clk);
        drive(4'b0000, 0);
        repeat (2) @(negedge clk);
        chk("R8 empty before overrun", 32'(out_valid), 32'd0);

        // overrun: fill with watchpoints while consumer stalls
        out_ready = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            drive(4'b0001, 0);
            wp_data = PW'(k);
            @(posedge clk); @(negedge clk);
        end
        drive(4'b1000, 40);
        @(posedge clk); @(negedge clk);
        chk("R5 ovr_active set", 32'(ovr_active), 32'd1);
        drive(4'b0110, 41);
        out_ready = 1'b1;
        #0.1;
        chk("R5 br_lost while draining", 32'(br_lost), 32'd1);
        ngot = 0;
        for (int n = 0; n < 20; n++) begin
            if (out_valid && ngot < 20) begin
                got_k[ngot] = out_kind;
                got_p[ngot] = out_data;
                ngot++;
            end
            @(posedge clk); @(negedge clk);
            drive(4'b0000, 0);
        end
        chk("R5 entries after overrun", 32'(ngot), 32'(DEPTH + 1));
        for (int k = 0; k < DEPTH; k++) begin
            chk($sformatf("R5 drained kind %0d", k), 32'(got_k[k]), 32'd0);
            chk($sformatf("R5 drained payload %0d", k), 32'(got_p[k]), 32'(k));
        end
        chk("R6 error kind", 32'(got_k[DEPTH]), 32'd4);
        chk("R6 error mask", 32'(got_p[DEPTH]), 32'h1E);
        chk("R6 ovr_active cleared", 32'(ovr_active), 32'd0);
        chk("R7 sync_req after overrun", 32'(sync_req), 32'd1);

        out_ready = 1'b0;
        drive(4'b0100, 50);
        @(posedge clk); @(negedge clk);
        drive(4'b0000, 0);
        chk("R7 branch after overrun kind", 32'(out_kind), 32'd2);
        chk("R7 branch after overrun sync", 32'(out_sync), 32'd1);
        chk("R7 sync_req cleared", 32'(sync_req), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule